// File: doc/BRIEF.md
# Dual-Side Inter-Processor Mailbox

This block lets two processors, called side A and side B, exchange words and signals over one shared clock. Each side has its own small register port with a word address, a write strobe, a read strobe and a read-data return. Each side sees a control register, a status register, four transmit slots and four receive slots. A word written into transmit slot N on one side is held until the opposite side reads its receive slot N, and full/empty status bits on both ends track each slot.

Apart from data words, each side can raise four general-purpose requests at the far side. It can also publish a 3-bit flag value that the far side sees after a short delivery interval, and it reports its own 2-bit power state to the far side. Each side has one level interrupt output, built from its status bits and its enable bits.

Register addresses on each port: 0 control, 1 status, 2 to 5 transmit slots 0 to 3 (writes only, they read as zero), 6 to 9 receive slots 0 to 3, and every other address reads as zero.

Top module: `ipc_mailbox`

## Requirements
- R1: A word written to address 2+N on one side is returned by a read of address 6+N on the other side.
- R2: Status bit 23-N is transmit-empty for slot N and status bit 27-N is receive-full for slot N. A transmit write clears the sender's bit 23-N and sets the receiver's bit 27-N. A read of the receive slot restores both bits in the next cycle.
- R3: A transmit write to a slot that is still full is dropped, and the receiver later reads the first word.
- R4: Writing 1 to control bit 19-N sets status bit 31-N on the far side in the next cycle, and control bit 19-N then reads 1. It reads 0 one cycle after the far side clears that pending bit. Writing 0 to a trigger bit has no effect.
- R5: Writing 1 to status bit 31-N clears that pending bit. A status write with 0 in that bit leaves it set.
- R6: A control write places bits 2:0 in the own flag field, which reads back in control bits 2:0. The far side's status bits 2:0 show the value two cycles later. Status bit 19 is 1 during those two cycles, and a control write during that time leaves the flag field unchanged.
- R7: Status bit 18 (event pending) is 1 exactly when status bit 19 is 1 or any own trigger bit 19:16 is 1.
- R8: Status bits 17:16 show the other side's power-mode input (0 run, 1 wait, 2 stop, 3 deep sleep).
- R9: A side's interrupt is 1 exactly when some status bit in 31:20 and the control bit at the same position (enables at 31:28, 27:24 and 23:20) are both 1.
- R10: After reset both control registers read 0, and each status register reads only the four transmit-empty bits plus the far power mode.
- R11: The two sides behave the same way, with the roles of A and B swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe (pops a receive slot) |
| a_addr | input | 4 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_pmode | input | 2 | Side A power state, reported to B |
| a_rdata | output | 32 | Side A read data (combinational) |
| a_irq | output | 1 | Side A interrupt |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe (pops a receive slot) |
| b_addr | input | 4 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_pmode | input | 2 | Side B power state, reported to A |
| b_rdata | output | 32 | Side B read data (combinational) |
| b_irq | output | 1 | Side B interrupt |

## Verification
Message transfer is tried three ways: with a distinct word in every slot (this catches swapped slot indices), with a second write to a slot that is still full (this separates dropped writes from overwrites), and with a write and a read of the same slot in one cycle (this shows which of the two takes priority). Requests are raised on two channels at once and accepted one at a time, so a clear that hits the wrong channel shows up. Back-to-back flag writes separate a blocked update from an accepted one. Traffic in the B-to-A direction shows whether the two sides are wired symmetrically.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

    localparam int NCH  = 4;
    localparam int DW   = 32;
    localparam int AW   = 4;
    localparam int CHW  = $clog2(NCH);
    localparam int FLW  = 3;

    localparam logic [AW-1:0] ADDR_CTL    = 4'd0;
    localparam logic [AW-1:0] ADDR_STS    = 4'd1;
    localparam logic [AW-1:0] ADDR_TX0    = 4'd2;
    localparam logic [AW-1:0] ADDR_RX0    = 4'd6;
    localparam logic [AW-1:0] ADDR_TX_END = ADDR_TX0 + AW'(NCH);
    localparam logic [AW-1:0] ADDR_RX_END = ADDR_RX0 + AW'(NCH);

    localparam int GP_HI   = 31;
    localparam int RX_HI   = 27;
    localparam int TX_HI   = 23;
    localparam int TRIG_HI = 19;
    localparam int FUP_BIT = 19;
    localparam int EP_BIT  = 18;
    localparam int PM_LO   = 16;
    localparam int IRQ_LO  = 20;

    typedef logic [NCH-1:0]        chvec_t;
    typedef logic [NCH-1:0][DW-1:0] slot_arr_t;

    typedef struct packed {
        chvec_t gp;
        chvec_t rx;
        chvec_t tx;
    } irq_en_t;

    typedef struct packed {
        chvec_t          pend;
        chvec_t          rx_full;
        chvec_t          tx_empty;
        logic            fup;
        logic            ep;
        logic [1:0]      pm;
        logic [FLW-1:0]  flags;
    } side_status_t;

    // channel n sits at bit (hi - n)
    function automatic chvec_t fld_get(logic [DW-1:0] w, int hi);
        chvec_t r;
        for (int n = 0; n < NCH; n++) r[n] = w[hi-n];
        return r;
    endfunction

    function automatic logic [DW-1:0] fld_put(chvec_t v, int hi);
        logic [DW-1:0] r;
        r = '0;
        for (int n = 0; n < NCH; n++) r[hi-n] = v[n];
        return r;
    endfunction

    function automatic logic [DW-1:0] pack_status(side_status_t s);
        logic [DW-1:0] r;
        r = fld_put(s.pend, GP_HI) | fld_put(s.rx_full, RX_HI) | fld_put(s.tx_empty, TX_HI);
        r[FUP_BIT]        = s.fup;
        r[EP_BIT]         = s.ep;
        r[PM_LO+1:PM_LO]  = s.pm;
        r[FLW-1:0]        = s.flags;
        return r;
    endfunction

    function automatic logic [DW-1:0] pack_ctrl(irq_en_t en, chvec_t trig, logic [FLW-1:0] fl);
        logic [DW-1:0] r;
        r = fld_put(en.gp, GP_HI) | fld_put(en.rx, RX_HI) | fld_put(en.tx, TX_HI)
          | fld_put(trig, TRIG_HI);
        r[FLW-1:0] = fl;
        return r;
    endfunction

endpackage

// File: rtl/ipc_msg_lane.sv
module ipc_msg_lane
    import ipc_mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CHW-1:0]   wr_ch,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    input  logic [CHW-1:0]   rd_ch,
    output chvec_t           full,
    output slot_arr_t        data
);

    for (genvar n = 0; n < NCH; n++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                full[n] <= 1'b0;
                data[n] <= '0;
            end else if (wr_en && wr_ch == CHW'(n) && !full[n]) begin
                full[n] <= 1'b1;
                data[n] <= wr_data;
            end else if (rd_en && rd_ch == CHW'(n)) begin
                full[n] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ipc_side_ctl.sv
module ipc_side_ctl
    import ipc_mbox_pkg::*;
#(
    parameter int FUP_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic             sts_wr,
    input  logic [DW-1:0]    wdata,
    input  chvec_t           far_trig_set,
    input  chvec_t           far_pend,
    output irq_en_t          en,
    output chvec_t           trig,
    output chvec_t           trig_set,
    output chvec_t           pend,
    output logic [FLW-1:0]   flag_own,
    output logic [FLW-1:0]   flag_pub,
    output logic             fup,
    output logic             ep
);

    localparam int CNT_W = $clog2(FUP_CYCLES + 1);

    logic [CNT_W-1:0] fup_cnt;
    chvec_t           clr_req;
    chvec_t           trig_req;

    always_comb begin
        clr_req  = sts_wr ? fld_get(wdata, GP_HI)   : '0;
        trig_req = ctl_wr ? fld_get(wdata, TRIG_HI) : '0;
        trig_set = trig_req & ~trig;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en       <= '0;
            trig     <= '0;
            pend     <= '0;
            flag_own <= '0;
            flag_pub <= '0;
            fup_cnt  <= '0;
        end else begin
            if (ctl_wr) begin
                en <= '{gp: fld_get(wdata, GP_HI),
                        rx: fld_get(wdata, RX_HI),
                        tx: fld_get(wdata, TX_HI)};
            end
            // a trigger stays up while the far side still holds it pending
            trig <= trig_set | (trig & far_pend);
            pend <= (pend & ~clr_req) | far_trig_set;
            if (fup_cnt == '0) begin
                if (ctl_wr) begin
                    flag_own <= wdata[FLW-1:0];
                    fup_cnt  <= CNT_W'(FUP_CYCLES);
                end
            end else begin
                fup_cnt <= fup_cnt - 1'b1;
                if (fup_cnt == CNT_W'(1)) flag_pub <= flag_own;
            end
        end
    end

    assign fup = (fup_cnt != '0);
    assign ep  = fup | (|trig);

endmodule

// File: rtl/ipc_side_port.sv
module ipc_side_port
    import ipc_mbox_pkg::*;
(
    input  logic [AW-1:0]   addr,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [DW-1:0]   ctrl_word,
    input  logic [DW-1:0]   status_word,
    input  slot_arr_t       rx_data,
    output logic            ctl_wr,
    output logic            sts_wr,
    output logic            tx_wr,
    output logic [CHW-1:0]  tx_ch,
    output logic            rx_rd,
    output logic [CHW-1:0]  rx_ch,
    output logic [DW-1:0]   rdata,
    output logic            irq
);

    logic          in_tx;
    logic          in_rx;
    logic [AW-1:0] tx_off;
    logic [AW-1:0] rx_off;

    always_comb begin
        in_tx  = (addr >= ADDR_TX0) && (addr < ADDR_TX_END);
        in_rx  = (addr >= ADDR_RX0) && (addr < ADDR_RX_END);
        tx_off = addr - ADDR_TX0;
        rx_off = addr - ADDR_RX0;
        tx_ch  = tx_off[CHW-1:0];
        rx_ch  = rx_off[CHW-1:0];
        ctl_wr = wr_en && (addr == ADDR_CTL);
        sts_wr = wr_en && (addr == ADDR_STS);
        tx_wr  = wr_en && in_tx;
        rx_rd  = rd_en && in_rx;

        if (addr == ADDR_CTL)      rdata = ctrl_word;
        else if (addr == ADDR_STS) rdata = status_word;
        else if (in_rx)            rdata = rx_data[rx_ch];
        else                       rdata = '0;

        irq = |(ctrl_word[DW-1:IRQ_LO] & status_word[DW-1:IRQ_LO]);
    end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int FUP_CYCLES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           a_wr_en,
    input  logic           a_rd_en,
    input  logic [3:0]     a_addr,
    input  logic [31:0]    a_wdata,
    input  logic [1:0]     a_pmode,
    output logic [31:0]    a_rdata,
    output logic           a_irq,
    input  logic           b_wr_en,
    input  logic           b_rd_en,
    input  logic [3:0]     b_addr,
    input  logic [31:0]    b_wdata,
    input  logic [1:0]     b_pmode,
    output logic [31:0]    b_rdata,
    output logic           b_irq
);

    // decode results
    logic a_ctl_wr, a_sts_wr, a_tx_wr, a_rx_rd;
    logic b_ctl_wr, b_sts_wr, b_tx_wr, b_rx_rd;
    logic [CHW-1:0] a_tx_ch, a_rx_ch, b_tx_ch, b_rx_ch;

    // lanes: ab carries A->B, ba carries B->A
    chvec_t    ab_full, ba_full;
    slot_arr_t ab_data, ba_data;

    // per-side control state
    irq_en_t        a_en, b_en;
    chvec_t         a_trig, b_trig, a_trig_set, b_trig_set, a_pend, b_pend;
    logic [FLW-1:0] a_flag_own, b_flag_own, a_flag_pub, b_flag_pub;
    logic           a_fup, b_fup, a_ep, b_ep;

    logic [DW-1:0]  a_ctrl_word, b_ctrl_word, a_status_word, b_status_word;

    ipc_msg_lane u_lane_ab (
        .clk(clk), .rst(rst),
        .wr_en(a_tx_wr), .wr_ch(a_tx_ch), .wr_data(a_wdata),
        .rd_en(b_rx_rd), .rd_ch(b_rx_ch),
        .full(ab_full), .data(ab_data)
    );

    ipc_msg_lane u_lane_ba (
        .clk(clk), .rst(rst),
        .wr_en(b_tx_wr), .wr_ch(b_tx_ch), .wr_data(b_wdata),
        .rd_en(a_rx_rd), .rd_ch(a_rx_ch),
        .full(ba_full), .data(ba_data)
    );

    ipc_side_ctl #(.FUP_CYCLES(FUP_CYCLES)) u_ctl_a (
        .clk(clk), .rst(rst),
        .ctl_wr(a_ctl_wr), .sts_wr(a_sts_wr), .wdata(a_wdata),
        .far_trig_set(b_trig_set), .far_pend(b_pend),
        .en(a_en), .trig(a_trig), .trig_set(a_trig_set), .pend(a_pend),
        .flag_own(a_flag_own), .flag_pub(a_flag_pub), .fup(a_fup), .ep(a_ep)
    );

    ipc_side_ctl #(.FUP_CYCLES(FUP_CYCLES)) u_ctl_b (
        .clk(clk), .rst(rst),
        .ctl_wr(b_ctl_wr), .sts_wr(b_sts_wr), .wdata(b_wdata),
        .far_trig_set(a_trig_set), .far_pend(a_pend),
        .en(b_en), .trig(b_trig), .trig_set(b_trig_set), .pend(b_pend),
        .flag_own(b_flag_own), .flag_pub(b_flag_pub), .fup(b_fup), .ep(b_ep)
    );

    always_comb begin
        a_ctrl_word   = pack_ctrl(a_en, a_trig, a_flag_own);
        b_ctrl_word   = pack_ctrl(b_en, b_trig, b_flag_own);
        a_status_word = pack_status('{pend: a_pend, rx_full: ba_full, tx_empty: ~ab_full,
                                      fup: a_fup, ep: a_ep, pm: b_pmode, flags: b_flag_pub});
        b_status_word = pack_status('{pend: b_pend, rx_full: ab_full, tx_empty: ~ba_full,
                                      fup: b_fup, ep: b_ep, pm: a_pmode, flags: a_flag_pub});
    end

    ipc_side_port u_port_a (
        .addr(a_addr), .wr_en(a_wr_en), .rd_en(a_rd_en),
        .ctrl_word(a_ctrl_word), .status_word(a_status_word), .rx_data(ba_data),
        .ctl_wr(a_ctl_wr), .sts_wr(a_sts_wr), .tx_wr(a_tx_wr), .tx_ch(a_tx_ch),
        .rx_rd(a_rx_rd), .rx_ch(a_rx_ch), .rdata(a_rdata), .irq(a_irq)
    );

    ipc_side_port u_port_b (
        .addr(b_addr), .wr_en(b_wr_en), .rd_en(b_rd_en),
        .ctrl_word(b_ctrl_word), .status_word(b_status_word), .rx_data(ab_data),
        .ctl_wr(b_ctl_wr), .sts_wr(b_sts_wr), .tx_wr(b_tx_wr), .tx_ch(b_tx_ch),
        .rx_rd(b_rx_rd), .rx_ch(b_rx_ch), .rdata(b_rdata), .irq(b_irq)
    );

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
    import ipc_mbox_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           a_wr_en,
    input logic [3:0]     a_addr,
    input chvec_t         ab_full,
    input slot_arr_t      ab_data,
    input chvec_t         a_trig,
    input chvec_t         b_trig,
    input chvec_t         a_pend,
    input chvec_t         b_pend,
    input irq_en_t        a_en,
    input irq_en_t        b_en,
    input logic [FLW-1:0] a_flag_own,
    input logic [FLW-1:0] b_flag_own,
    input logic [FLW-1:0] a_flag_pub,
    input logic           a_fup,
    input logic           a_irq,
    input logic           b_irq
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (a_en == '0 && b_en == '0 && a_trig == '0 && b_trig == '0
                 && a_flag_own == '0 && b_flag_own == '0)); // R10

    AST_TRIG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (a_trig & b_pend) != '0 |=> (($past(a_trig & b_pend) & ~a_trig) == '0)); // R4

    AST_TRIG_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (b_trig & ~a_pend) != '0 |=> (($past(b_trig & ~a_pend) & b_trig) == '0)); // R4

    AST_FLAG_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        a_fup |=> $stable(a_flag_own)); // R6

    AST_FLAG_DELIVERED: assert property (@(posedge clk) disable iff (rst)
        $fell(a_fup) |-> (a_flag_pub == a_flag_own)); // R6

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (a_en == '0) |-> !a_irq); // R9

    AST_IRQ_MASKED_B: assert property (@(posedge clk) disable iff (rst)
        (b_en == '0) |-> !b_irq); // R11

    for (genvar n = 0; n < NCH; n++) begin : g_drop
        AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
            (a_wr_en && a_addr == ADDR_TX0 + AW'(n) && ab_full[n])
            |=> (ab_data[n] == $past(ab_data[n]))); // R3
    end

endmodule

bind ipc_mailbox ipc_mailbox_chk chk_i (
    .clk(clk), .rst(rst), .a_wr_en(a_wr_en), .a_addr(a_addr),
    .ab_full(ab_full), .ab_data(ab_data),
    .a_trig(a_trig), .b_trig(b_trig), .a_pend(a_pend), .b_pend(b_pend),
    .a_en(a_en), .b_en(b_en), .a_flag_own(a_flag_own), .b_flag_own(b_flag_own),
    .a_flag_pub(a_flag_pub), .a_fup(a_fup), .a_irq(a_irq), .b_irq(b_irq)
);

// File: tb/ipc_mailbox_tb_top.sv
`timescale 1ns/1ps
module ipc_mailbox_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        wr [2];
    logic        rd [2];
    logic [3:0]  ad [2];
    logic [31:0] wd [2];
    logic [1:0]  pm [2];
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    ipc_mailbox dut_i (
        .clk(clk), .rst(rst),
        .a_wr_en(wr[0]), .a_rd_en(rd[0]), .a_addr(ad[0]), .a_wdata(wd[0]), .a_pmode(pm[0]),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_wr_en(wr[1]), .b_rd_en(rd[1]), .b_addr(ad[1]), .b_wdata(wd[1]), .b_pmode(pm[1]),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    // behavioural reference state; lane s carries words sent by side s
    bit          full [2][4];
    logic [31:0] data [2][4];
    logic [11:0] en   [2];
    bit          trig [2][4];
    bit          pend [2][4];
    logic [2:0]  fown [2];
    logic [2:0]  fpub [2];
    int          cnt  [2];

    int    vectors = 0;
    int    fails   = 0;
    string cur_req = "R10";

    function automatic logic [31:0] m_ctl(int s);
        logic [31:0] r = '0;
        r[31:20] = en[s];
        for (int n = 0; n < 4; n++) r[19-n] = trig[s][n];
        r[2:0] = fown[s];
        return r;
    endfunction

    function automatic logic [31:0] m_sts(int s);
        logic [31:0] r = '0;
        int o = 1 - s;
        bit any = 0;
        for (int n = 0; n < 4; n++) begin
            r[31-n] = pend[s][n];
            r[27-n] = full[o][n];
            r[23-n] = !full[s][n];
            any |= trig[s][n];
        end
        r[19] = (cnt[s] != 0);
        r[18] = (cnt[s] != 0) || any;
        r[17:16] = pm[o];
        r[2:0] = fpub[o];
        return r;
    endfunction

    function automatic logic [31:0] m_rd(int s);
        if (ad[s] == 0) return m_ctl(s);
        if (ad[s] == 1) return m_sts(s);
        if (ad[s] >= 6 && ad[s] <= 9) return data[1-s][ad[s]-6];
        return '0;
    endfunction

    function automatic logic m_irq(int s);
        logic [31:0] c = m_ctl(s), t = m_sts(s);
        return |(c[31:20] & t[31:20]);
    endfunction

    task automatic m_reset();
        for (int s = 0; s < 2; s++) begin
            for (int n = 0; n < 4; n++) begin
                full[s][n] = 0; data[s][n] = '0; trig[s][n] = 0; pend[s][n] = 0;
            end
            en[s] = '0; fown[s] = '0; fpub[s] = '0; cnt[s] = 0;
        end
    endtask

    task automatic m_step();
        bit          nfull [2][4];
        logic [31:0] ndata [2][4];
        bit          ntrig [2][4];
        bit          npend [2][4];
        for (int s = 0; s < 2; s++)
            for (int n = 0; n < 4; n++) begin
                nfull[s][n] = full[s][n]; ndata[s][n] = data[s][n];
                ntrig[s][n] = trig[s][n]; npend[s][n] = pend[s][n];
            end
        for (int s = 0; s < 2; s++) begin
            int o = 1 - s;
            for (int n = 0; n < 4; n++) begin
                if (wr[s] && ad[s] == 4'(2 + n) && !full[s][n]) begin
                    nfull[s][n] = 1; ndata[s][n] = wd[s];
                end else if (rd[o] && ad[o] == 4'(6 + n) && full[s][n]) begin
                    nfull[s][n] = 0;
                end
                if (trig[s][n] && !pend[o][n]) ntrig[s][n] = 0;
                if (wr[s] && ad[s] == 1 && wd[s][31-n]) npend[s][n] = 0;
            end
        end
        for (int s = 0; s < 2; s++) begin
            int o = 1 - s;
            for (int n = 0; n < 4; n++)
                if (wr[s] && ad[s] == 0 && wd[s][19-n] && !trig[s][n]) begin
                    ntrig[s][n] = 1; npend[o][n] = 1;
                end
            if (wr[s] && ad[s] == 0) en[s] = wd[s][31:20];
            if (cnt[s] == 0) begin
                if (wr[s] && ad[s] == 0) begin fown[s] = wd[s][2:0]; cnt[s] = 2; end
            end else begin
                if (cnt[s] == 1) fpub[s] = fown[s];
                cnt[s]--;
            end
        end
        for (int s = 0; s < 2; s++)
            for (int n = 0; n < 4; n++) begin
                full[s][n] = nfull[s][n]; data[s][n] = ndata[s][n];
                trig[s][n] = ntrig[s][n]; pend[s][n] = npend[s][n];
            end
    endtask

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // one clock: drive, compare outputs before the edge, advance the model
    task automatic cyc(logic w0, logic r0, logic [3:0] a0, logic [31:0] d0,
                       logic w1, logic r1, logic [3:0] a1, logic [31:0] d1);
        wr[0] = w0; rd[0] = r0; ad[0] = a0; wd[0] = d0;
        wr[1] = w1; rd[1] = r1; ad[1] = a1; wd[1] = d1;
        #1;
        chk(cur_req, "side A rdata", a_rdata, m_rd(0));
        chk(cur_req, "side B rdata", b_rdata, m_rd(1));
        chk("R9", "side A irq", {31'b0, a_irq}, {31'b0, m_irq(0)});
        chk("R9", "side B irq", {31'b0, b_irq}, {31'b0, m_irq(1)});
        @(posedge clk);
        m_step();
        @(negedge clk);
    endtask

    task automatic wrA(logic [3:0] a, logic [31:0] d); cyc(1, 0, a, d, 0, 0, 1, 0); endtask
    task automatic wrB(logic [3:0] a, logic [31:0] d); cyc(0, 0, 0, 0, 1, 0, a, d); endtask
    task automatic rdA(logic [3:0] a); cyc(0, 1, a, 0, 0, 0, 1, 0); endtask
    task automatic rdB(logic [3:0] a); cyc(0, 0, 1, 0, 0, 1, a, 0); endtask

    function automatic logic [31:0] ctlw(logic [3:0] gie, logic [3:0] rie, logic [3:0] tie,
                                         logic [3:0] trg, logic [2:0] fl);
        logic [31:0] r = '0;
        for (int n = 0; n < 4; n++) begin
            r[31-n] = gie[n]; r[27-n] = rie[n]; r[23-n] = tie[n]; r[19-n] = trg[n];
        end
        r[2:0] = fl;
        return r;
    endfunction

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            wr[s] = 0; rd[s] = 0; ad[s] = 0; wd[s] = 0; pm[s] = 0;
        end
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        cur_req = "R10";
        cyc(0, 1, 0, 0, 0, 1, 0, 0);
        cyc(0, 1, 1, 0, 0, 1, 1, 0);

        cur_req = "R1";
        for (int n = 0; n < 4; n++) wrA(4'(2 + n), 32'hA500_0000 + 32'(n * 17 + 3));
        cur_req = "R2";
        rdB(1); rdA(1);
        cur_req = "R1";
        for (int n = 0; n < 4; n++) rdB(4'(6 + n));
        cur_req = "R2";
        rdA(1); rdB(1);

        cur_req = "R11";
        wrB(4, 32'h1234_5678); rdA(1); rdA(8); rdA(1); rdB(1);

        cur_req = "R3";
        wrA(3, 32'h0000_1111); wrA(3, 32'h0000_2222); rdB(1); rdB(7); rdB(7); rdB(1);

        cur_req = "R2";
        wrA(5, 32'hCAFE_0005);
        cyc(1, 0, 5, 32'hDEAD_0005, 0, 1, 9, 0);
        rdB(1); rdB(9); rdB(1);

        cur_req = "R4";
        wrA(0, ctlw(4'b0000, 4'b0000, 4'b0000, 4'b0101, 3'd0));
        rdB(1); rdA(0);
        cur_req = "R7";
        rdA(1);
        cur_req = "R4";
        wrA(0, ctlw(4'b0000, 4'b0000, 4'b0000, 4'b0000, 3'd0));
        rdA(0);
        cur_req = "R5";
        wrB(1, 32'h0000_0000); rdB(1);
        wrB(1, 32'h8000_0000); rdB(1);
        cur_req = "R4";
        rdA(0); rdA(0);
        cur_req = "R5";
        wrB(1, 32'h2000_0000);
        cur_req = "R7";
        rdA(1); rdA(1); rdA(1);

        cur_req = "R6";
        wrA(0, ctlw(0, 0, 0, 0, 3'd5));
        cyc(1, 0, 0, ctlw(0, 0, 0, 0, 3'd2), 0, 0, 1, 0);
        rdB(1); rdB(1); rdA(0); rdB(1);
        cur_req = "R11";
        wrB(0, ctlw(0, 0, 0, 0, 3'd6)); rdA(1); rdA(1); rdA(1);

        cur_req = "R8";
        pm[0] = 2'd2; pm[1] = 2'd3;
        rdB(1); rdA(1);
        pm[0] = 2'd1;
        rdB(1);

        cur_req = "R9";
        wrB(0, ctlw(4'b0000, 4'b0010, 4'b0000, 4'b0000, 3'd0));
        rdB(1);
        wrA(3, 32'h0000_00AA); rdB(1); rdB(7); rdB(1);
        wrA(0, ctlw(4'b0000, 4'b0000, 4'b1000, 4'b0000, 3'd0)); rdA(1);
        wrB(0, ctlw(4'b0100, 4'b0000, 4'b0000, 4'b0100, 3'd0)); rdA(1); rdB(1);
        wrA(0, ctlw(4'b0010, 4'b0000, 4'b0000, 4'b0000, 3'd0)); rdA(1);
        wrA(1, 32'h2000_0000); rdA(1); rdB(0); rdB(0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule